// File: doc/BRIEF.md
# Nine-bit command/data serial transmitter

This block drives a display controller over a three-wire serial link made of a clock, a data line and an active-low chip select. It has no separate command/data pin. Instead, every byte leaves the block as a nine-bit frame. The first bit of the frame tells the panel whether the remaining eight bits are a command or data.

Bytes arrive on a valid/ready interface. Each byte carries a command/data flag and a marker for the last byte of a burst. Chip select stays low for the whole burst, including any pause while the block waits for the next byte. When the alignment input is set at the start of a burst, the block appends filler command frames after the last byte. It adds as many as it needs to bring the burst's total bit count up to a multiple of eight, so a downstream byte-oriented link or capture buffer never sees a partial byte.

The serial clock is derived from the system clock by a half-period divider parameter. With the default of 10 cycles and a 200 MHz system clock, the serial clock period is 100 ns, which is the fastest the panel allows.

Top module: `nine_bit_link_tx`

## Requirements
- R1: Each frame is 9 bits. The selector bit goes out first, followed by the 8 payload bits, most significant bit first. The data line is stable for the whole of each high phase of the serial clock.
- R2: The selector bit is 0 for a byte presented with `in_is_data` = 0 (command) and 1 for a byte presented with `in_is_data` = 1 (data).
- R3: The link uses clock mode 0. `sclk` is low whenever `cs_n` is high, and the panel samples the data line on the rising edge of `sclk`.
- R4: Each high phase of `sclk` lasts exactly `HALF_DIV` system cycles.
- R5: `cs_n` falls on the clock edge that accepts the first byte of a burst, and the first bit is on `sdo` at that moment. The first `sclk` rising edge follows `HALF_DIV` cycles later. `cs_n` rises `HALF_DIV` cycles after the final falling edge of `sclk`, and that final edge includes any filler frames.
- R6: With alignment on, a burst of n frames is followed by (8 − n mod 8) mod 8 filler frames. Each filler frame has selector 0 and payload `FILL_CODE` (default 0x5C).
- R7: With alignment off, no filler frames are sent, and the burst is exactly 9·n bits long.
- R8: `align_en` is sampled only when the first byte of a burst is accepted. Changing it during the burst has no effect on that burst.
- R9: `in_ready` is high only while the link is idle or waiting between frames of a burst. During such a wait `sclk` stays low and `cs_n` stays low. No byte is accepted while a frame is shifting.
- R10: `busy` is high exactly while `cs_n` is low.
- R11: After reset, `cs_n` = 1, `sclk` = 0, `busy` = 0 and `in_ready` = 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| align_en | input | 1 | Pad each burst to a whole number of bytes with filler frames |
| in_valid | input | 1 | A byte is offered |
| in_ready | output | 1 | A byte is accepted on this cycle when in_valid is high |
| in_byte | input | 8 | Payload byte |
| in_is_data | input | 1 | 1 = data byte, 0 = command byte |
| in_last | input | 1 | Marks the final byte of the burst |
| sclk | output | 1 | Serial clock, idles low |
| sdo | output | 1 | Serial data out |
| cs_n | output | 1 | Chip select, active low |
| busy | output | 1 | High while a burst is in progress |

## Verification
The hardest condition to reach from the ports is the end of a burst while the link is paused between frames. The filler decision must then use the frame count accumulated across the stall. The alignment setting captured at the burst start must also win over a value that has changed since then. The stimulus reaches this state in three ways. It withholds `in_valid` for longer than a frame takes, so the block sits in its inter-frame wait. It toggles `align_en` right after the first byte is accepted. It sends burst lengths on both sides of a multiple of eight (1, 8, 9, 16), so both the zero-padding case and the seven-filler case are exercised.

// File: rtl/nbt_pkg.sv
package nbt_pkg;
  localparam int BYTE_BITS  = 8;
  localparam int FRAME_BITS = BYTE_BITS + 1;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SHIFT = 2'd1,
    ST_WAIT  = 2'd2,
    ST_TAIL  = 2'd3
  } nbt_state_e;

  typedef struct packed {
    logic                 is_data;
    logic [BYTE_BITS-1:0] payload;
  } nbt_frame_t;
endpackage

// File: rtl/nbt_half_timer.sv
// Emits one tick every HALF_DIV cycles while enabled; restart realigns the phase.
module nbt_half_timer #(
  parameter int HALF_DIV = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic restart,
  output logic tick
);
  localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);

  logic [CW-1:0] cnt_q, cnt_d;

  assign tick = en && !restart && (cnt_q == LAST);

  always_comb begin
    cnt_d = cnt_q;
    if (restart || !en) begin
      cnt_d = '0;
    end else if (tick) begin
      cnt_d = '0;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/nbt_frame_counter.sv
// Counts frames of a burst modulo ALIGN_FRAMES; pad_more is high when the
// frame now ending would leave the burst off a byte boundary.
module nbt_frame_counter #(
  parameter int ALIGN_FRAMES = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic inc,
  output logic pad_more
);
  localparam int CW = (ALIGN_FRAMES > 1) ? $clog2(ALIGN_FRAMES) : 1;
  localparam logic [CW-1:0] WRAP = CW'(ALIGN_FRAMES - 1);

  logic [CW-1:0] cnt_q, cnt_d;

  assign pad_more = (cnt_q != WRAP);

  always_comb begin
    cnt_d = cnt_q;
    if (clear)    cnt_d = '0;
    else if (inc) cnt_d = (cnt_q == WRAP) ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/nbt_ctrl.sv
// Burst sequencer and frame shifter.
module nbt_ctrl
  import nbt_pkg::*;
#(
  parameter logic [BYTE_BITS-1:0] FILL_CODE = 8'h5C
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 align_en,
  input  logic                 in_valid,
  input  logic [BYTE_BITS-1:0] in_byte,
  input  logic                 in_is_data,
  input  logic                 in_last,
  input  logic                 tick,
  input  logic                 pad_more,
  output logic                 in_ready,
  output logic                 timer_en,
  output logic                 timer_restart,
  output logic                 cnt_clear,
  output logic                 cnt_inc,
  output logic                 sclk,
  output logic                 sdo,
  output logic                 cs_n
);
  localparam int BW = $clog2(FRAME_BITS);
  localparam logic [BW-1:0] TOP_BIT = BW'(FRAME_BITS - 1);

  nbt_state_e           state_q, state_d;
  logic [FRAME_BITS-1:0] shreg_q, shreg_d;
  logic [BW-1:0]         bit_q, bit_d;
  logic                  sclk_q, sclk_d;
  logic                  last_q, last_d;
  logic                  align_q, align_d;
  nbt_frame_t            in_frame, fill_frame;

  assign in_frame   = '{is_data: in_is_data, payload: in_byte};
  assign fill_frame = '{is_data: 1'b0, payload: FILL_CODE};

  always_comb begin
    state_d       = state_q;
    shreg_d       = shreg_q;
    bit_d         = bit_q;
    sclk_d        = sclk_q;
    last_d        = last_q;
    align_d       = align_q;
    in_ready      = 1'b0;
    timer_en      = 1'b0;
    timer_restart = 1'b0;
    cnt_clear     = 1'b0;
    cnt_inc       = 1'b0;
    unique case (state_q)
      ST_IDLE, ST_WAIT: begin
        in_ready = 1'b1;
        if (in_valid) begin
          shreg_d       = in_frame;
          bit_d         = TOP_BIT;
          last_d        = in_last;
          timer_restart = 1'b1;
          state_d       = ST_SHIFT;
          if (state_q == ST_IDLE) begin
            align_d   = align_en;
            cnt_clear = 1'b1;
          end
        end
      end
      ST_SHIFT: begin
        timer_en = 1'b1;
        if (tick) begin
          if (!sclk_q) begin
            sclk_d = 1'b1;
          end else begin
            sclk_d = 1'b0;
            if (bit_q == '0) begin
              cnt_inc = 1'b1;
              if (!last_q) begin
                state_d = ST_WAIT;
              end else if (align_q && pad_more) begin
                shreg_d = fill_frame;
                bit_d   = TOP_BIT;
              end else begin
                state_d = ST_TAIL;
              end
            end else begin
              shreg_d = {shreg_q[FRAME_BITS-2:0], 1'b0};
              bit_d   = bit_q - 1'b1;
            end
          end
        end
      end
      ST_TAIL: begin
        timer_en = 1'b1;
        if (tick) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      shreg_q <= '0;
      bit_q   <= '0;
      sclk_q  <= 1'b0;
      last_q  <= 1'b0;
      align_q <= 1'b0;
    end else begin
      state_q <= state_d;
      shreg_q <= shreg_d;
      bit_q   <= bit_d;
      sclk_q  <= sclk_d;
      last_q  <= last_d;
      align_q <= align_d;
    end
  end

  assign sclk = sclk_q;
  assign sdo  = shreg_q[FRAME_BITS-1];
  assign cs_n = (state_q == ST_IDLE);
endmodule

// File: rtl/nine_bit_link_tx.sv
module nine_bit_link_tx
  import nbt_pkg::*;
#(
  parameter int                   HALF_DIV  = 10,
  parameter logic [BYTE_BITS-1:0] FILL_CODE = 8'h5C
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 align_en,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic [BYTE_BITS-1:0] in_byte,
  input  logic                 in_is_data,
  input  logic                 in_last,
  output logic                 sclk,
  output logic                 sdo,
  output logic                 cs_n,
  output logic                 busy
);
  // 9*n bits is byte aligned only when n is a multiple of the byte width.
  localparam int ALIGN_FRAMES = BYTE_BITS;

  logic tick, timer_en, timer_restart, cnt_clear, cnt_inc, pad_more;

  nbt_half_timer #(.HALF_DIV(HALF_DIV)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (timer_en),
    .restart (timer_restart),
    .tick    (tick)
  );

  nbt_frame_counter #(.ALIGN_FRAMES(ALIGN_FRAMES)) u_count (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (cnt_clear),
    .inc      (cnt_inc),
    .pad_more (pad_more)
  );

  nbt_ctrl #(.FILL_CODE(FILL_CODE)) u_ctrl (
    .clk           (clk),
    .rst_n         (rst_n),
    .align_en      (align_en),
    .in_valid      (in_valid),
    .in_byte       (in_byte),
    .in_is_data    (in_is_data),
    .in_last       (in_last),
    .tick          (tick),
    .pad_more      (pad_more),
    .in_ready      (in_ready),
    .timer_en      (timer_en),
    .timer_restart (timer_restart),
    .cnt_clear     (cnt_clear),
    .cnt_inc       (cnt_inc),
    .sclk          (sclk),
    .sdo           (sdo),
    .cs_n          (cs_n)
  );

  assign busy = !cs_n;
endmodule

// File: rtl/nbt_checks.sv
module nbt_checks #(
  parameter int HALF_DIV = 10
) (
  input logic clk,
  input logic rst_n,
  input logic sclk,
  input logic sdo,
  input logic cs_n,
  input logic in_ready
);
  logic [15:0] hi_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    hi_cnt <= '0;
    else if (sclk) hi_cnt <= hi_cnt + 1'b1;
    else           hi_cnt <= '0;
  end

  assert_sdo_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk && $past(sclk)) |-> $stable(sdo));

  assert_idle_clock_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !sclk);

  assert_high_phase_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sclk) |-> (hi_cnt == 16'(HALF_DIV)));

  assert_release_after_fall_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_n) |-> $past(!sclk));

  assert_ready_clock_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> !sclk);
endmodule

bind nine_bit_link_tx nbt_checks #(.HALF_DIV(HALF_DIV)) u_checks (
  .clk      (clk),
  .rst_n    (rst_n),
  .sclk     (sclk),
  .sdo      (sdo),
  .cs_n     (cs_n),
  .in_ready (in_ready)
);

// File: tb/tb_nine_bit_link_tx.sv
`timescale 1ns/1ps
module tb_nine_bit_link_tx;
  localparam int HALF = 10;
  localparam logic [7:0] FILL = 8'h5C;
  localparam int NVEC = 8;
  // {frame count, align, seed}
  localparam logic [23:0] VEC [0:NVEC-1] = '{
    {8'd1,  8'd0, 8'hA5}, {8'd1,  8'd1, 8'h3C}, {8'd3,  8'd1, 8'h11},
    {8'd8,  8'd1, 8'h80}, {8'd9,  8'd1, 8'hF1}, {8'd5,  8'd0, 8'h42},
    {8'd16, 8'd1, 8'h07}, {8'd2,  8'd1, 8'hC8}
  };

  logic clk = 1'b0;
  logic rst_n, align_en, in_valid, in_is_data, in_last;
  logic [7:0] in_byte;
  logic in_ready, sclk, sdo, cs_n, busy;

  always #2.5 clk = ~clk;

  nine_bit_link_tx #(.HALF_DIV(HALF), .FILL_CODE(FILL)) dut (
    .clk(clk), .rst_n(rst_n), .align_en(align_en), .in_valid(in_valid),
    .in_ready(in_ready), .in_byte(in_byte), .in_is_data(in_is_data),
    .in_last(in_last), .sclk(sclk), .sdo(sdo), .cs_n(cs_n), .busy(busy)
  );

  int total = 0, bad = 0;
  bit finished = 0;
  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // serial monitor
  logic bits [0:2047];
  int nbits = 0;
  logic sclk_p = 1'b0, cs_p = 1'b1;
  int cs_fall_cyc, first_rise_cyc, rise_cyc, fall_cyc;
  int lead_len, hi_len, tail_len, clk_at_csfall;
  bit first_seen;

  always @(negedge clk) begin
    if (rst_n) begin
      if (cs_p && !cs_n) begin
        nbits = 0; cs_fall_cyc = cyc; first_seen = 0; clk_at_csfall = sclk;
      end
      if (!sclk_p && sclk) begin
        if (nbits < 2048) bits[nbits] = sdo;
        nbits++;
        rise_cyc = cyc;
        if (!first_seen) begin first_seen = 1; lead_len = cyc - cs_fall_cyc; end
      end
      if (sclk_p && !sclk) begin fall_cyc = cyc; hi_len = cyc - rise_cyc; end
      if (!cs_p && cs_n) tail_len = cyc - fall_cyc;
    end
    sclk_p = sclk; cs_p = cs_n;
  end

  task automatic check(bit ok, string req, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [7:0] byte_of(logic [7:0] seed, int k);
    return seed + 8'(k * 37);
  endfunction

  function automatic logic sel_of(logic [7:0] seed, int k);
    if (k == 0) return 1'b0;
    return seed[0] ? logic'(k[0]) : 1'b1;
  endfunction

  task automatic send_burst(int n, bit a0, bit a1, logic [7:0] seed, int gap);
    @(negedge clk);
    align_en = a0;
    for (int k = 0; k < n; k++) begin
      if (k > 0 && gap > 0) begin
        repeat (gap) @(negedge clk);
        check(sclk == 0 && cs_n == 0, "R9 stall holds clock low, select low", {30'd0, sclk, cs_n}, 0);
        check(in_ready == 1, "R9 ready while waiting", in_ready, 1);
        check(busy == 1, "R10 busy during stall", busy, 1);
      end
      in_valid = 1'b1; in_byte = byte_of(seed, k);
      in_is_data = sel_of(seed, k); in_last = (k == n - 1);
      while (!in_ready) @(negedge clk);
      @(negedge clk);
      in_valid = 1'b0;
      if (k == 0) align_en = a1;
      if (k == 0 && gap > 0) begin
        repeat (3 * HALF) @(negedge clk);
        check(in_ready == 0, "R9 no accept mid frame", in_ready, 0);
      end
    end
    while (!cs_n) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic verify_burst(int n, bit a, logic [7:0] seed);
    int pad = a ? (8 - n % 8) % 8 : 0;
    int dmis = 0, fmis = 0;
    for (int f = 0; f < n + pad; f++) begin
      logic [8:0] w, e;
      for (int b = 0; b < 9; b++) w[8-b] = bits[9*f+b];
      e = (f < n) ? {sel_of(seed, f), byte_of(seed, f)} : {1'b0, FILL};
      if (w !== e) begin
        if (f < n) dmis++; else fmis++;
      end
    end
    check(nbits == 9 * (n + pad), a ? "R6 padded length" : "R7 unpadded length", nbits, 9 * (n + pad));
    check(dmis == 0, "R1 R2 frame content", dmis, 0);
    check(fmis == 0, "R6 filler frames", fmis, 0);
    check(lead_len == HALF, "R5 select lead", lead_len, HALF);
    check(tail_len == HALF, "R5 select tail", tail_len, HALF);
    check(hi_len == HALF, "R4 high phase", hi_len, HALF);
    check(clk_at_csfall == 0, "R3 clock low at select", clk_at_csfall, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; align_en = 1'b0; in_valid = 1'b0;
    in_byte = '0; in_is_data = 1'b0; in_last = 1'b0;
    repeat (4) @(negedge clk);
    // R11 reset state
    check(cs_n == 1, "R11 cs_n", cs_n, 1);
    check(sclk == 0, "R11 sclk", sclk, 0);
    check(busy == 0, "R11 busy", busy, 0);
    check(in_ready == 1, "R11 in_ready", in_ready, 1);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    for (int v = 0; v < NVEC; v++) begin
      int n = int'(VEC[v][23:16]);
      bit a = VEC[v][8];
      send_burst(n, a, a, VEC[v][7:0], 0);
      verify_burst(n, a, VEC[v][7:0]);
      check(busy == 0 && cs_n == 1, "R10 idle after burst", busy, 0);
    end

    // R8: alignment captured at start, switched off mid burst
    send_burst(2, 1'b1, 1'b0, 8'h5A, 0);
    verify_burst(2, 1'b1, 8'h5A);
    // R8: alignment off at start, switched on mid burst
    send_burst(3, 1'b0, 1'b1, 8'h9D, 0);
    verify_burst(3, 1'b0, 8'h9D);

    // R9: stall between frames longer than a frame, then align pad
    send_burst(3, 1'b1, 1'b1, 8'h21, 250);
    verify_burst(3, 1'b1, 8'h21);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule